// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Encoder and Corrector

This block protects an 8-bit data byte with 4 check bits, giving a 12-bit protected word. The encoder side takes a byte and emits the 12-bit word, with the check bits at the power-of-two positions and the data bits filling the other positions. The corrector side takes a 12-bit word that may have picked up a fault. It recomputes each check from the bits that check covers and forms a 4-bit syndrome. It then decodes the syndrome to a single bit position and inverts that bit before extracting the byte.

Each side has its own valid strobe, and each is registered by one pipeline stage. Alongside the corrected byte, the corrector reports the syndrome and two flags. One flag says that a single-bit fault was located and repaired. The other says that the syndrome names a position beyond the end of the 12-bit word. The output registers load only on a cycle that carries a valid input, and hold their value on every other cycle.

Top module: `ham_sec_top`

## Requirements
- R1: Check bits are k0 = d0^d1^d3^d4^d6, k1 = d0^d2^d3^d5^d6, k2 = d1^d2^d3^d7 and k3 = d4^d5^d6^d7.
- R2: Word position p (1 to 12) sits at bit p-1 of the 12-bit bus. Check bits k0, k1, k2 and k3 sit at positions 1, 2, 4 and 8. Data bits d0 to d7 sit, in ascending order, at positions 3, 5, 6, 7, 9, 10, 11 and 12.
- R3: A received word whose syndrome is 0 yields its data bits unchanged, with both the repaired flag and the out-of-range flag low.
- R4: A single inverted data position p yields syndrome p, the original byte and the repaired flag high.
- R5: A single inverted check position (1, 2, 4 or 8) yields that position as the syndrome, the data bits unchanged and the repaired flag high.
- R6: A syndrome of 13, 14 or 15 raises the out-of-range flag, keeps the repaired flag low and passes the received data bits through unmodified.
- R7: Each output appears on the cycle after its valid input, with its valid output high for exactly that cycle. Outputs hold their value while the valid input is low.
- R8: After reset, both valid outputs and all data, syndrome and flag outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| encValidIn | input | 1 | Encoder input strobe |
| encDataIn | input | 8 | Byte to protect |
| decValidIn | input | 1 | Corrector input strobe |
| decWordIn | input | 12 | Received protected word |
| encValidOut | output | 1 | Encoder output valid |
| encWordOut | output | 12 | Protected word |
| decValidOut | output | 1 | Corrector output valid |
| decDataOut | output | 8 | Corrected byte |
| decSyndrome | output | 4 | Syndrome of the received word |
| decFixed | output | 1 | Single-bit fault located and repaired |
| decBad | output | 1 | Syndrome beyond the last position |

## Verification
The encoder is driven with all-zero, all-one, alternating and single-one bytes. These patterns separate each of the four check equations from the others and expose any misplaced data position. The corrector is first given clean words. Then it is given every one of the 12 single-bit faults on two different bytes, which separates data-position repair from check-position repair and confirms that the syndrome equals the faulty position. Two-bit faults that produce syndromes 13, 14 and 15 exercise the out-of-range path. Idle cycles with changed inputs confirm that the outputs hold.

// File: rtl/ham_sec_pkg.sv
package ham_sec_pkg;

  typedef struct packed {
    logic encLoad;
    logic decLoad;
  } strobe_t;

  function automatic bit isPow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // Position (1-based) of data bit i: the (i+1)-th non-power-of-two position.
  function automatic int posOfData(input int i);
    int n;
    int p;
    n = 0;
    p = 0;
    while (n <= i) begin
      p = p + 1;
      if (!isPow2(p)) n = n + 1;
    end
    return p;
  endfunction

endpackage

// File: rtl/ham_sec_ctrl.sv
module ham_sec_ctrl
  import ham_sec_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    encValidIn,
  input  logic    decValidIn,
  output strobe_t strb,
  output logic    encValidOut,
  output logic    decValidOut
);

  always_comb begin
    strb.encLoad = encValidIn;
    strb.decLoad = decValidIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encValidOut <= 1'b0;
      decValidOut <= 1'b0;
    end else begin
      encValidOut <= encValidIn;
      decValidOut <= decValidIn;
    end
  end

endmodule

// File: rtl/ham_sec_dp.sv
module ham_sec_dp
  import ham_sec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 4,
  localparam int CW_W  = DATA_W + CHK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] encDataIn,
  input  logic [CW_W-1:0]   decWordIn,
  output logic [CW_W-1:0]   encWordOut,
  output logic [DATA_W-1:0] decDataOut,
  output logic [CHK_W-1:0]  decSyndrome,
  output logic              decFixed,
  output logic              decBad
);

  // Positions covered by check k: every position whose index has bit k set.
  function automatic logic [CW_W-1:0] covMask(input int k);
    logic [CW_W-1:0] m;
    m = '0;
    for (int p = 1; p <= CW_W; p++) begin
      if (((p >> k) & 1) == 1) m[p-1] = 1'b1;
    end
    return m;
  endfunction

  logic [CW_W-1:0]   placedData;
  logic [CHK_W-1:0]  encChk;
  logic [CW_W-1:0]   encWordNext;
  logic [CHK_W-1:0]  syn;
  logic [CW_W-1:0]   posHit;
  logic [DATA_W-1:0] decDataNext;
  logic              fixedNext;
  logic              badNext;

  // Data placement and extraction at the non-power-of-two positions
  for (genvar i = 0; i < DATA_W; i++) begin : g_data
    localparam int P = posOfData(i);
    assign placedData[P-1]  = encDataIn[i];
    assign encWordNext[P-1] = encDataIn[i];
    assign decDataNext[i]   = decWordIn[P-1] ^ posHit[P-1];
  end

  // Check bits and syndrome bits, one per covering mask
  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam logic [CW_W-1:0] MASK = covMask(k);
    assign placedData[(1 << k) - 1]  = 1'b0;
    assign encChk[k]                 = ^(placedData & MASK);
    assign encWordNext[(1 << k) - 1] = encChk[k];
    assign syn[k]                    = ^(decWordIn & MASK);

    // R1: every registered encoder word has zero parity over each mask
    p_enc_parity_r1: assert property (@(posedge clk) disable iff (!rstN)
      strb.encLoad |=> ((^(encWordOut & MASK)) == 1'b0));
  end

  // One-hot position decoder driving the bit flip
  for (genvar p = 1; p <= CW_W; p++) begin : g_pos
    assign posHit[p-1] = (syn == CHK_W'(p));
  end

  assign fixedNext = |posHit;
  assign badNext   = (syn != '0) && !fixedNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encWordOut  <= '0;
      decDataOut  <= '0;
      decSyndrome <= '0;
      decFixed    <= 1'b0;
      decBad      <= 1'b0;
    end else begin
      if (strb.encLoad) encWordOut <= encWordNext;
      if (strb.decLoad) begin
        decDataOut  <= decDataNext;
        decSyndrome <= syn;
        decFixed    <= fixedNext;
        decBad      <= badNext;
      end
    end
  end

  p_syn_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (decSyndrome == '0) |-> (!decFixed && !decBad));

  p_flag_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    decFixed |-> !decBad);

  p_bad_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    decBad |-> (decSyndrome > CHK_W'(CW_W)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.decLoad |=> ($stable(decDataOut) && $stable(decSyndrome)));

endmodule

// File: rtl/ham_sec_top.sv
module ham_sec_top
  import ham_sec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 4,
  localparam int CW_W  = DATA_W + CHK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              encValidIn,
  input  logic [DATA_W-1:0] encDataIn,
  input  logic              decValidIn,
  input  logic [CW_W-1:0]   decWordIn,
  output logic              encValidOut,
  output logic [CW_W-1:0]   encWordOut,
  output logic              decValidOut,
  output logic [DATA_W-1:0] decDataOut,
  output logic [CHK_W-1:0]  decSyndrome,
  output logic              decFixed,
  output logic              decBad
);

  strobe_t strb;

  ham_sec_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .encValidIn (encValidIn),
    .decValidIn (decValidIn),
    .strb       (strb),
    .encValidOut(encValidOut),
    .decValidOut(decValidOut)
  );

  ham_sec_dp #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .encDataIn  (encDataIn),
    .decWordIn  (decWordIn),
    .encWordOut (encWordOut),
    .decDataOut (decDataOut),
    .decSyndrome(decSyndrome),
    .decFixed   (decFixed),
    .decBad     (decBad)
  );

  // R7: the corrector valid follows its input strobe by one cycle
  p_dec_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    decValidIn |=> decValidOut);

  p_enc_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    !encValidIn |=> !encValidOut);

endmodule

// File: tb/ham_sec_top_bench.sv
`timescale 1ns/1ps
module ham_sec_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        encValidIn = 1'b0;
  logic [7:0]  encDataIn = '0;
  logic        decValidIn = 1'b0;
  logic [11:0] decWordIn = '0;
  logic        encValidOut;
  logic [11:0] encWordOut;
  logic        decValidOut;
  logic [7:0]  decDataOut;
  logic [3:0]  decSyndrome;
  logic        decFixed;
  logic        decBad;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ham_sec_top u_ham_sec_top (
    .clk(clk), .rstN(rstN),
    .encValidIn(encValidIn), .encDataIn(encDataIn),
    .decValidIn(decValidIn), .decWordIn(decWordIn),
    .encValidOut(encValidOut), .encWordOut(encWordOut),
    .decValidOut(decValidOut), .decDataOut(decDataOut),
    .decSyndrome(decSyndrome), .decFixed(decFixed), .decBad(decBad)
  );

  // Reference model written from R1 and R2
  function automatic logic [3:0] refChk(input logic [7:0] d);
    logic [3:0] c;
    c[0] = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    c[1] = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c[2] = d[1] ^ d[2] ^ d[3] ^ d[7];
    c[3] = d[4] ^ d[5] ^ d[6] ^ d[7];
    return c;
  endfunction

  function automatic logic [11:0] refEnc(input logic [7:0] d);
    logic [3:0] c;
    c = refChk(d);
    return {d[7], d[6], d[5], d[4], c[3], d[3], d[2], d[1], c[2], d[0], c[1], c[0]};
  endfunction

  function automatic logic [7:0] refData(input logic [11:0] w);
    return {w[11], w[10], w[9], w[8], w[6], w[5], w[4], w[2]};
  endfunction

  function automatic logic [3:0] refSyn(input logic [11:0] w);
    logic [3:0] c;
    c = refChk(refData(w));
    return {w[7] ^ c[3], w[3] ^ c[2], w[1] ^ c[1], w[0] ^ c[0]};
  endfunction

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runEnc(input logic [7:0] d);
    @(negedge clk);
    encValidIn = 1'b1; encDataIn = d;
    @(negedge clk);
    encValidIn = 1'b0;
    checkEq("R7 enc valid", 32'(encValidOut), 32'd1);
    checkEq("R1 R2 enc word", 32'(encWordOut), 32'(refEnc(d)));
    @(negedge clk);
    checkEq("R7 enc valid drop", 32'(encValidOut), 32'd0);
  endtask

  task automatic runDec(input string tag, input logic [11:0] w,
                        input logic [7:0] expData, input logic [3:0] expSyn,
                        input logic expFixed, input logic expBad);
    @(negedge clk);
    decValidIn = 1'b1; decWordIn = w;
    @(negedge clk);
    decValidIn = 1'b0;
    checkEq({tag, " valid R7"}, 32'(decValidOut), 32'd1);
    checkEq({tag, " data"}, 32'(decDataOut), 32'(expData));
    checkEq({tag, " syndrome"}, 32'(decSyndrome), 32'(expSyn));
    checkEq({tag, " fixed"}, 32'(decFixed), 32'(expFixed));
    checkEq({tag, " bad"}, 32'(decBad), 32'(expBad));
  endtask

  task automatic testReset();
    @(negedge clk);
    checkEq("R8 enc valid", 32'(encValidOut), 32'd0);
    checkEq("R8 dec valid", 32'(decValidOut), 32'd0);
    checkEq("R8 enc word", 32'(encWordOut), 32'd0);
    checkEq("R8 dec data", 32'(decDataOut), 32'd0);
    checkEq("R8 syndrome", 32'(decSyndrome), 32'd0);
    checkEq("R8 flags", 32'({decFixed, decBad}), 32'd0);
  endtask

  task automatic testEncode();
    runEnc(8'h00); runEnc(8'hFF); runEnc(8'hA5); runEnc(8'h5A);
    for (int i = 0; i < 8; i++) runEnc(8'(1 << i));
  endtask

  task automatic testClean();
    runDec("R3 clean 00", refEnc(8'h00), 8'h00, 4'd0, 1'b0, 1'b0);
    runDec("R3 clean FF", refEnc(8'hFF), 8'hFF, 4'd0, 1'b0, 1'b0);
    runDec("R3 clean 3C", refEnc(8'h3C), 8'h3C, 4'd0, 1'b0, 1'b0);
  endtask

  task automatic testSingle(input logic [7:0] d);
    for (int p = 1; p <= 12; p++) begin
      logic [11:0] w;
      w = refEnc(d) ^ (12'd1 << (p - 1));
      if (p == 1 || p == 2 || p == 4 || p == 8)
        runDec("R5 check fault", w, d, 4'(p), 1'b1, 1'b0);
      else
        runDec("R4 data fault", w, d, 4'(p), 1'b1, 1'b0);
    end
  endtask

  task automatic testOutOfRange();
    logic [11:0] base;
    logic [11:0] w;
    base = refEnc(8'h96);
    w = base ^ 12'h801;  // positions 12 and 1 -> 13
    runDec("R6 syn13", w, refData(w), 4'd13, 1'b0, 1'b1);
    checkEq("R6 syn13 model", 32'(refSyn(w)), 32'd13);
    w = base ^ 12'h802;  // positions 12 and 2 -> 14
    runDec("R6 syn14", w, refData(w), 4'd14, 1'b0, 1'b1);
    w = base ^ 12'h804;  // positions 12 and 3 -> 15
    runDec("R6 syn15", w, refData(w), 4'd15, 1'b0, 1'b1);
  endtask

  task automatic testHold();
    runDec("R7 hold setup", refEnc(8'h71), 8'h71, 4'd0, 1'b0, 1'b0);
    @(negedge clk);
    decWordIn = 12'hFFF; encDataIn = 8'h0F;
    @(negedge clk);
    @(negedge clk);
    checkEq("R7 hold data", 32'(decDataOut), 32'h71);
    checkEq("R7 hold syndrome", 32'(decSyndrome), 32'd0);
    checkEq("R7 hold valid low", 32'(decValidOut), 32'd0);
    checkEq("R7 hold enc word", 32'(encWordOut), 32'(refEnc(8'h80)));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEncode();
    testClean();
    testSingle(8'hC3);
    testSingle(8'h1E);
    testOutOfRange();
    testHold();
    finishRun();
  end

endmodule